// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block sits between a command source and the control pins of an embedded non-volatile array. It accepts one command at a time: a read, a word program, a page erase or a mass erase, each with an address, a data word and a select that steers the operation to the small information block instead of the main block. It then walks the array's eight control strobes through the required order. Every interval is held for at least its minimum time, and the timing rules differ between the program path and the erase paths.

Each interval is given in nanoseconds as a parameter. It is turned into a whole number of clock cycles from a clock-frequency parameter, always rounding up. A single down-counter measures whichever interval is active. The command source sees `busy` for the whole operation, including the final recovery gap, and a one-cycle `done` at the end. A read also returns the word it fetched.

Top module: `flash_seq`

## Requirements
- R1: The control vector, written as bits [7:0] = {XE, YE, SE, OE, PROG, ERASE, MAS1, NVSTR}, is 8'h00 when idle and during recovery. It is 8'hF0 during a read, 8'hC9 during the program strobe, 8'h85 while a page erase is held, and 8'h87 while a mass erase is held.
- R2: PROG (program) or ERASE (page and mass erase) is raised with XE for T_NVS before NVSTR rises. The vector is 8'h88 for program, 8'h84 for page erase and 8'h86 for mass erase.
- R3: In a word program, NVSTR is high with PROG for T_PGS (8'h89) before YE rises. YE stays high for T_PROG. YE is then low for T_PGH (8'h89) before PROG falls.
- R4: ERASE with NVSTR is held for T_ERASE in a page erase and for T_ME in a mass erase.
- R5: After PROG or ERASE falls, NVSTR stays high alone with XE for T_NVH (8'h81). After a mass erase it stays high for T_NVH1, with MAS1 still high (8'h83).
- R6: After NVSTR falls, all strobes stay low for T_RCV before the operation ends. A read has no recovery gap.
- R7: Each interval lasts exactly ceil(t_ns × CLK_MHZ / 1000) cycles, with a minimum of one cycle.
- R8: `busy` rises in the cycle after a command is accepted and falls when the last interval ends. In that same cycle `done` is high, for exactly one cycle. A read holds 8'hF0 for T_READ, and `rd_data` then holds the addressed word.
- R9: A command presented while `busy` is high is ignored. The running sequence and its pins are unchanged, and no extra operation follows.
- R10: cmd_op is 0 for read, 1 for program, 2 for page erase and 3 for mass erase. With `cmd_ifren`=1, a read, program or page erase targets the information block, and a mass erase clears both blocks. With `cmd_ifren`=0, only the main block is used.
- R11: A page erase clears only the 256-word page selected by the address bits above bit 7.
- R12: `fl_addr`, `fl_din` and `fl_ifren` stay constant from the cycle after acceptance until `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (R10) |
| cmd_addr | input | AW | Word address |
| cmd_data | input | DW | Word to program |
| cmd_ifren | input | 1 | Information-block select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| rd_data | output | DW | Word fetched by the last read |
| fl_xe | output | 1 | Row enable strobe |
| fl_ye | output | 1 | Column enable / program strobe |
| fl_se | output | 1 | Sense amplifier enable |
| fl_oe | output | 1 | Output enable |
| fl_prog | output | 1 | Program cycle strobe |
| fl_erase | output | 1 | Erase cycle strobe |
| fl_mas1 | output | 1 | Whole-block erase strobe |
| fl_nvstr | output | 1 | Non-volatile store strobe |
| fl_ifren | output | 1 | Information-block select to array |
| fl_addr | output | AW | Address to array |
| fl_din | output | DW | Data to array |
| fl_dout | input | DW | Data from array |

## Verification
The in-RTL properties watch the ordering on every cycle: NVSTR only rises after PROG or ERASE, the YE strobe only appears under NVSTR, MAS1 only appears with erase or store, address, data and select are stable while busy, `done` is a single cycle, and a command arriving while busy leaves the latched command alone. The exact length of each interval, the rounding up, and the effect of the block select and the page boundaries on stored contents can only be shown by the bench. It reconstructs every run of a constant control vector and reads back data through a behavioural array model.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ       = 2'd0,
    OP_PROG       = 2'd1,
    OP_PAGE_ERASE = 2'd2,
    OP_MASS_ERASE = 2'd3
  } flash_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_READ,
    ST_P_SETUP,
    ST_P_NVS,
    ST_P_STROBE,
    ST_P_HOLD,
    ST_E_SETUP,
    ST_E_HOLD,
    ST_NV_HOLD,
    ST_RECOVER
  } seq_state_e;

  typedef struct packed {
    logic xe;
    logic ye;
    logic se;
    logic oe;
    logic prog;
    logic erase;
    logic mas1;
    logic nvstr;
  } flash_ctrl_t;

  // Round a duration up to whole cycles, never below one cycle.
  function automatic int ns_to_cycles(longint t_ns, longint clk_mhz);
    longint c;
    c = (t_ns * clk_mhz + 64'd999) / 64'd1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R7: an expired counter stays at zero until reloaded.
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
(
  input  seq_state_e  state,
  input  logic        mass,
  output flash_ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_READ: begin
        ctrl.xe = 1'b1; ctrl.ye = 1'b1; ctrl.se = 1'b1; ctrl.oe = 1'b1;
      end
      ST_P_SETUP: begin
        ctrl.xe = 1'b1; ctrl.prog = 1'b1;
      end
      ST_P_NVS, ST_P_HOLD: begin
        ctrl.xe = 1'b1; ctrl.prog = 1'b1; ctrl.nvstr = 1'b1;
      end
      ST_P_STROBE: begin
        ctrl.xe = 1'b1; ctrl.ye = 1'b1; ctrl.prog = 1'b1; ctrl.nvstr = 1'b1;
      end
      ST_E_SETUP: begin
        ctrl.xe = 1'b1; ctrl.erase = 1'b1; ctrl.mas1 = mass;
      end
      ST_E_HOLD: begin
        ctrl.xe = 1'b1; ctrl.erase = 1'b1; ctrl.mas1 = mass; ctrl.nvstr = 1'b1;
      end
      ST_NV_HOLD: begin
        ctrl.xe = 1'b1; ctrl.mas1 = mass; ctrl.nvstr = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 13,
  parameter int DW        = 16,
  parameter int CLK_MHZ   = 80,
  parameter int T_READ_NS = 40,
  parameter int T_NVS_NS  = 5000,
  parameter int T_PGS_NS  = 10000,
  parameter int T_PROG_NS = 20000,
  parameter int T_PGH_NS  = 100,
  parameter int T_NVH_NS  = 5000,
  parameter int T_NVH1_NS = 100000,
  parameter int T_RCV_NS  = 1000,
  parameter int T_ERASE_NS = 20000000,
  parameter int T_ME_NS   = 100000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_ifren,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          fl_xe,
  output logic          fl_ye,
  output logic          fl_se,
  output logic          fl_oe,
  output logic          fl_prog,
  output logic          fl_erase,
  output logic          fl_mas1,
  output logic          fl_nvstr,
  output logic          fl_ifren,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_din,
  input  logic [DW-1:0] fl_dout
);

  localparam longint MHZ = longint'(CLK_MHZ);
  localparam int C_READ  = ns_to_cycles(longint'(T_READ_NS),  MHZ);
  localparam int C_NVS   = ns_to_cycles(longint'(T_NVS_NS),   MHZ);
  localparam int C_PGS   = ns_to_cycles(longint'(T_PGS_NS),   MHZ);
  localparam int C_PROG  = ns_to_cycles(longint'(T_PROG_NS),  MHZ);
  localparam int C_PGH   = ns_to_cycles(longint'(T_PGH_NS),   MHZ);
  localparam int C_NVH   = ns_to_cycles(longint'(T_NVH_NS),   MHZ);
  localparam int C_NVH1  = ns_to_cycles(longint'(T_NVH1_NS),  MHZ);
  localparam int C_RCV   = ns_to_cycles(longint'(T_RCV_NS),   MHZ);
  localparam int C_ERASE = ns_to_cycles(longint'(T_ERASE_NS), MHZ);
  localparam int C_ME    = ns_to_cycles(longint'(T_ME_NS),    MHZ);
  localparam int C_SUM   = C_READ + C_NVS + C_PGS + C_PROG + C_PGH + C_NVH
                         + C_NVH1 + C_RCV + C_ERASE + C_ME;
  localparam int CW      = $clog2(C_SUM + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  seq_state_e    state_q, state_d;
  flash_op_e     op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rd_q;
  logic          ifren_q, done_q;
  logic          accept, expired, load, rd_cap, finish, mass;
  logic [CW-1:0] load_val;
  flash_ctrl_t   ctrl;

  assign mass = (op_q == OP_MASS_ERASE);

  // Next-state and interval selection
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        accept = 1'b1;
        unique case (flash_op_e'(cmd_op))
          OP_READ: state_d = ST_READ;
          OP_PROG: state_d = ST_P_SETUP;
          default: state_d = ST_E_SETUP;
        endcase
      end
      ST_READ:     if (expired) state_d = ST_IDLE;
      ST_P_SETUP:  if (expired) state_d = ST_P_NVS;
      ST_P_NVS:    if (expired) state_d = ST_P_STROBE;
      ST_P_STROBE: if (expired) state_d = ST_P_HOLD;
      ST_P_HOLD:   if (expired) state_d = ST_NV_HOLD;
      ST_E_SETUP:  if (expired) state_d = ST_E_HOLD;
      ST_E_HOLD:   if (expired) state_d = ST_NV_HOLD;
      ST_NV_HOLD:  if (expired) state_d = ST_RECOVER;
      ST_RECOVER:  if (expired) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase

    load = (state_d != state_q);
    unique case (state_d)
      ST_READ:     load_val = CW'(C_READ - 1);
      ST_P_SETUP,
      ST_E_SETUP:  load_val = CW'(C_NVS - 1);
      ST_P_NVS:    load_val = CW'(C_PGS - 1);
      ST_P_STROBE: load_val = CW'(C_PROG - 1);
      ST_P_HOLD:   load_val = CW'(C_PGH - 1);
      ST_E_HOLD:   load_val = mass ? CW'(C_ME - 1) : CW'(C_ERASE - 1);
      ST_NV_HOLD:  load_val = mass ? CW'(C_NVH1 - 1) : CW'(C_NVH - 1);
      ST_RECOVER:  load_val = CW'(C_RCV - 1);
      default:     load_val = '0;
    endcase

    rd_cap = (state_q == ST_READ) && expired;
    finish = (state_q != ST_IDLE) && (state_d == ST_IDLE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      ifren_q <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        op_q    <= flash_op_e'(cmd_op);
        addr_q  <= cmd_addr;
        data_q  <= cmd_data;
        ifren_q <= cmd_ifren;
      end
      if (rd_cap) begin
        rd_q <= fl_dout;
      end
    end
  end

  flash_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  flash_seq_decode u_decode (
    .state (state_q),
    .mass  (mass),
    .ctrl  (ctrl)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign rd_data  = rd_q;
  assign fl_xe    = ctrl.xe;
  assign fl_ye    = ctrl.ye;
  assign fl_se    = ctrl.se;
  assign fl_oe    = ctrl.oe;
  assign fl_prog  = ctrl.prog;
  assign fl_erase = ctrl.erase;
  assign fl_mas1  = ctrl.mas1;
  assign fl_nvstr = ctrl.nvstr;
  assign fl_ifren = ifren_q;
  assign fl_addr  = addr_q;
  assign fl_din   = data_q;

  // R2: the store strobe only rises after a program or erase strobe was up.
  a_r2_nvstr_after_mode: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(fl_nvstr) |-> $past(fl_prog || fl_erase));

  // R3: the column strobe of a program only appears under the store strobe.
  a_r3_strobe_under_nvstr: assert property (@(posedge clk) disable iff (!rst_s)
    (fl_ye && fl_prog) |-> (fl_nvstr && !fl_erase && !fl_se));

  // R5: whole-block strobe only alongside erase or store.
  a_r5_mas1_context: assert property (@(posedge clk) disable iff (!rst_s)
    fl_mas1 |-> (fl_erase || fl_nvstr));

  // R1: sensing, programming and erasing never overlap.
  a_r1_one_mode: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({fl_se, fl_prog, fl_erase}));

  // R8: done lasts one cycle and arrives with busy low.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !busy);

  // R9: a request while busy leaves the latched command alone.
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && cmd_valid) |=> ($stable(op_q) && $stable(addr_q)));

  // R12: array address, data and select stay put during an operation.
  a_r12_pins_stable: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> ($stable(fl_addr) && $stable(fl_din) && $stable(fl_ifren)));

endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int MHZ = 10;
  localparam int T_READ = 250, T_NVS = 5000, T_PGS = 10000, T_PROG = 20000;
  localparam int T_PGH = 150, T_NVH = 5000, T_NVH1 = 100000, T_RCV = 1000;
  localparam int T_ERASE = 3000, T_ME = 6000;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic cmd_ifren;
  logic busy, done;
  logic [DW-1:0] rd_data;
  logic fl_xe, fl_ye, fl_se, fl_oe, fl_prog, fl_erase, fl_mas1, fl_nvstr, fl_ifren;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_din, fl_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq #(
    .AW(AW), .DW(DW), .CLK_MHZ(MHZ), .T_READ_NS(T_READ), .T_NVS_NS(T_NVS),
    .T_PGS_NS(T_PGS), .T_PROG_NS(T_PROG), .T_PGH_NS(T_PGH), .T_NVH_NS(T_NVH),
    .T_NVH1_NS(T_NVH1), .T_RCV_NS(T_RCV), .T_ERASE_NS(T_ERASE), .T_ME_NS(T_ME)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ifren(cmd_ifren),
    .busy(busy), .done(done), .rd_data(rd_data),
    .fl_xe(fl_xe), .fl_ye(fl_ye), .fl_se(fl_se), .fl_oe(fl_oe),
    .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_mas1(fl_mas1), .fl_nvstr(fl_nvstr),
    .fl_ifren(fl_ifren), .fl_addr(fl_addr), .fl_din(fl_din), .fl_dout(fl_dout)
  );

  // Behavioural array stub: erased words read as all ones.
  logic [DW-1:0] arr_main [WORDS];
  logic [DW-1:0] arr_info [WORDS];
  logic ye_d;

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      arr_main[i] = '1;
      arr_info[i] = '1;
    end
  end

  always @(posedge clk) begin
    ye_d <= fl_ye;
    if (fl_xe && fl_ye && !ye_d && fl_prog && fl_nvstr) begin
      if (fl_ifren) arr_info[fl_addr] <= arr_info[fl_addr] & fl_din;
      else          arr_main[fl_addr] <= arr_main[fl_addr] & fl_din;
    end
    if (fl_erase && fl_nvstr) begin
      for (int i = 0; i < WORDS; i++) begin
        if (fl_mas1) begin
          arr_main[i] <= '1;
          if (fl_ifren) arr_info[i] <= '1;
        end else if (i[AW-1:8] == fl_addr[AW-1:8]) begin
          if (fl_ifren) arr_info[i] <= '1;
          else          arr_main[i] <= '1;
        end
      end
    end
  end

  always_comb begin
    if (fl_xe && fl_ye && fl_se && fl_oe)
      fl_dout = fl_ifren ? arr_info[fl_addr] : arr_main[fl_addr];
    else
      fl_dout = '0;
  end

  // Bench model of stored contents
  logic [DW-1:0] mdl_main [WORDS];
  logic [DW-1:0] mdl_info [WORDS];

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] vec;
    int         len;
    string      req;
  } run_t;

  run_t exp_q[$];
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_din;
  logic          exp_ifren;
  bit            mon_on = 0;

  function automatic int cyc(int t_ns);
    int c;
    c = (t_ns * MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [7:0] pins();
    return {fl_xe, fl_ye, fl_se, fl_oe, fl_prog, fl_erase, fl_mas1, fl_nvstr};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] v, int len, string req);
    run_t r;
    r.vec = v; r.len = len; r.req = req;
    exp_q.push_back(r);
  endtask

  // Monitor: rebuilds runs of a constant control vector while busy.
  logic [7:0] cur_vec;
  int  cur_len = 0;
  bit  in_run = 0;
  bit  pin_bad = 0;

  task automatic close_run();
    run_t r;
    if (exp_q.size() == 0) begin
      check(0, "R8", "unexpected run vec", cur_vec, 0);
    end else begin
      r = exp_q.pop_front();
      check(cur_vec == r.vec, r.req, "run vector", cur_vec, r.vec);
      check(cur_len == r.len, r.req, "run length", cur_len, r.len);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) begin
        if (in_run && pins() == cur_vec) cur_len++;
        else begin
          if (in_run) close_run();
          cur_vec = pins(); cur_len = 1; in_run = 1;
        end
        if (fl_addr != exp_addr || fl_din != exp_din || fl_ifren != exp_ifren) pin_bad = 1;
      end else if (in_run) begin
        close_run();
        in_run = 0;
        check(done == 1'b1, "R8", "done at busy fall", done, 1);
        check(exp_q.size() == 0, "R8", "runs left over", exp_q.size(), 0);
        check(!pin_bad, "R12", "pins changed while busy", pin_bad, 0);
        pin_bad = 0;
      end
    end
  end

  // Driver: posts expected runs, issues the command, waits for done.
  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic ifr, input bit inject);
    while (busy) @(negedge clk);
    exp_addr = a; exp_din = d; exp_ifren = ifr;
    case (op)
      2'd0: push(8'hF0, cyc(T_READ), "R8");
      2'd1: begin
        push(8'h88, cyc(T_NVS),  "R2");
        push(8'h89, cyc(T_PGS),  "R3");
        push(8'hC9, cyc(T_PROG), "R3");
        push(8'h89, cyc(T_PGH),  "R7");
        push(8'h81, cyc(T_NVH),  "R5");
        push(8'h00, cyc(T_RCV),  "R6");
      end
      2'd2: begin
        push(8'h84, cyc(T_NVS),   "R2");
        push(8'h85, cyc(T_ERASE), "R4");
        push(8'h81, cyc(T_NVH),   "R5");
        push(8'h00, cyc(T_RCV),   "R6");
      end
      default: begin
        push(8'h86, cyc(T_NVS),  "R2");
        push(8'h87, cyc(T_ME),   "R4");
        push(8'h83, cyc(T_NVH1), "R5");
        push(8'h00, cyc(T_RCV),  "R6");
      end
    endcase
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_ifren = ifr; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      // R9: a read to another address while busy must have no effect.
      cmd_op = 2'd0; cmd_addr = a ^ 10'h3FF; cmd_ifren = ~ifr; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    case (op)
      2'd1: if (ifr) mdl_info[a] = mdl_info[a] & d; else mdl_main[a] = mdl_main[a] & d;
      2'd2: for (int i = 0; i < WORDS; i++)
              if (i[AW-1:8] == a[AW-1:8]) begin
                if (ifr) mdl_info[i] = '1; else mdl_main[i] = '1;
              end
      2'd3: for (int i = 0; i < WORDS; i++) begin
              mdl_main[i] = '1;
              if (ifr) mdl_info[i] = '1;
            end
      default: ;
    endcase
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    check(busy == 1'b0, "R9", "no extra operation", busy, 0);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic ifr, input string req);
    logic [DW-1:0] e;
    e = ifr ? mdl_info[a] : mdl_main[a];
    run_op(2'd0, a, '0, ifr, 0);
    check(rd_data == e, req, "read data", rd_data, e);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mdl_main[i] = '1;
      mdl_info[i] = '1;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0; cmd_ifren = 1'b0;
    exp_addr = '0; exp_din = '0; exp_ifren = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: standby vector and idle handshake after reset.
    check(pins() == 8'h00, "R1", "reset vector", pins(), 0);
    check(busy == 1'b0 && done == 1'b0, "R8", "reset busy/done", {busy, done}, 0);
    mon_on = 1;

    read_chk(10'h005, 1'b0, "R8");                    // erased word
    run_op(2'd1, 10'h005, 16'hA5A5, 1'b0, 0);          // R3 program main
    read_chk(10'h005, 1'b0, "R3");
    run_op(2'd1, 10'h005, 16'h1234, 1'b1, 0);          // R10 program info
    read_chk(10'h005, 1'b1, "R10");
    read_chk(10'h005, 1'b0, "R10");
    run_op(2'd1, 10'h105, 16'h0F0F, 1'b0, 1);          // R9 with injected request
    read_chk(10'h105, 1'b0, "R9");
    run_op(2'd2, 10'h010, '0, 1'b0, 0);                // R11 erase main page 0
    read_chk(10'h005, 1'b0, "R11");
    read_chk(10'h105, 1'b0, "R11");
    read_chk(10'h005, 1'b1, "R10");
    run_op(2'd1, 10'h200, 16'h00AA, 1'b1, 0);
    run_op(2'd2, 10'h0FF, '0, 1'b1, 0);                // R10 erase info page 0
    read_chk(10'h005, 1'b1, "R10");
    read_chk(10'h200, 1'b1, "R11");
    run_op(2'd1, 10'h300, 16'h5555, 1'b0, 0);
    run_op(2'd3, 10'h000, '0, 1'b0, 0);                // R4 mass erase main only
    read_chk(10'h300, 1'b0, "R4");
    read_chk(10'h105, 1'b0, "R4");
    read_chk(10'h200, 1'b1, "R10");
    run_op(2'd3, 10'h000, '0, 1'b1, 0);                // R10 mass erase both
    read_chk(10'h200, 1'b1, "R10");
    check(cyc(T_PGH) == 2 && cyc(T_READ) == 3, "R7", "rounding up", cyc(T_PGH), 2);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule